// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of small saturating counters, one per slot, and picks the slot from a field of the branch instruction address. The fetch stage presents a program counter on the lookup port. One cycle later the block returns the slot's counter and a taken/not-taken guess, which is the counter's upper bit. On a predicted-taken result, fetch redirects to the branch target. Otherwise fetch carries on with the next sequential address.

When a branch resolves later in the pipeline, its address and real direction arrive on the update port. The block moves the slot's counter one step toward the real outcome, saturating at both ends. One cycle after the update it raises a mispredict flag if the upper bit of that counter, as it stood before the update, disagreed with the real outcome. The pipeline uses this flag to request a flush. Because each counter must move through two states before its upper bit changes, a single loop exit does not turn a strongly established guess around. This avoids the repeated misses that a single history bit would cause.

The block does not compute the target address. It does not perform the flush. It keeps no tags, so distinct branches that share an index share a counter.

Top module: `twobit_branch_predictor`

## Requirements
- R1: A synchronous active-high reset sets every counter to 2'b01 (weakly not-taken). The same reset clears `pred_valid`, `pred_ctr`, `pred_taken` and `mispredict`.
- R2: The slot index is PC[7:2]. Two addresses that differ only in bits [1:0] or in bits above 7 select the same counter.
- R3: After a cycle with `lk_valid` high, the following cycle shows `pred_valid`=1, `pred_ctr` equal to the slot's counter, and `pred_taken` equal to bit 1 of that counter.
- R4: An update with `up_taken`=1 adds one to the slot's counter. The counter saturates at 2'b11.
- R5: An update with `up_taken`=0 subtracts one from the slot's counter. The counter saturates at 2'b00.
- R6: In the cycle after an update, `mispredict` is 1 exactly when `up_taken` differs from bit 1 of the counter before the update. `mispredict` is 0 in the cycle after any cycle without an update.
- R7: Starting from 2'b11, one not-taken update still leaves the guess at taken. A second consecutive not-taken update turns it to not-taken. The same holds in mirror form starting from 2'b00.
- R8: When a lookup and an update address the same slot in the same cycle, the lookup returns the counter value from before that update.
- R9: An update changes only the counter of the slot it addresses.
- R10: After a cycle with `lk_valid` low, the following cycle shows `pred_valid`=0, `pred_ctr`=2'b00 and `pred_taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request from fetch |
| lk_pc | input | PC_W | Address of the instruction being fetched |
| pred_valid | output | 1 | Lookup result present (one cycle after the request) |
| pred_ctr | output | 2 | Counter value read for the lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved branch present |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |
| mispredict | output | 1 | Flush request for the update of the previous cycle |

## Verification
Lookup and update are the two functions that can fall in the same cycle, and they may target the same slot. The bench provokes this both by placing a lookup and an update on one address in one cycle, and in a long pseudo-random run where both ports are active with addresses drawn from a small pool so that they often collide. In every case a reference array of counters inside the bench is read for the expected lookup value before the bench applies that cycle's update. A lookup that sees the updated counter is therefore reported as a failure.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

  // Move a counter one step toward the resolved outcome, saturating at both ends.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) begin
      nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int IDX_W   = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr_q,
  output logic             rd_valid_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [1:0]       wr_old_ctr
);

  logic [2*ENTRIES-1:0] ctr_flat;

  // One saturating counter per slot. Each slot steps only when it is addressed.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= CTR_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        cell_q <= ctr_step(cell_q, wr_taken);
      end
    end
    assign ctr_flat[2*e +: 2] = cell_q;
  end

  // Read-modify-write source for the update port: the value before this edge.
  assign wr_old_ctr = ctr_flat[2*wr_idx +: 2];

  // Registered read port. It samples the pre-update contents at the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ctr_q   <= 2'b00;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      rd_ctr_q   <= rd_en ? ctr_flat[2*rd_idx +: 2] : 2'b00;
    end
  end

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_valid,
  input  logic       up_taken,
  input  logic [1:0] old_ctr,
  output logic       mispredict_q
);
  logic guessed_taken;
  assign guessed_taken = old_ctr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict_q <= 1'b0;
    end else begin
      mispredict_q <= up_valid && (up_taken != guessed_taken);
    end
  end
endmodule

// File: rtl/twobit_branch_predictor.sv
module twobit_branch_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic [1:0]      pred_ctr,
  output logic            pred_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  output logic            mispredict
);

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [1:0]       up_old_ctr;
  logic [1:0]       rd_ctr_q;
  logic             rd_valid_q;

  bp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_index (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  bp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_up_index (
    .pc  (up_pc),
    .idx (up_idx)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (lk_valid),
    .rd_idx     (lk_idx),
    .rd_ctr_q   (rd_ctr_q),
    .rd_valid_q (rd_valid_q),
    .wr_en      (up_valid),
    .wr_idx     (up_idx),
    .wr_taken   (up_taken),
    .wr_old_ctr (up_old_ctr)
  );

  bp_resolve u_resolve (
    .clk          (clk),
    .rst          (rst),
    .up_valid     (up_valid),
    .up_taken     (up_taken),
    .old_ctr      (up_old_ctr),
    .mispredict_q (mispredict)
  );

  assign pred_valid = rd_valid_q;
  assign pred_ctr   = rd_ctr_q;
  assign pred_taken = rd_ctr_q[1];

endmodule

// File: rtl/twobit_bp_checker.sv
module twobit_bp_checker (
  input logic       clk,
  input logic       rst,
  input logic       lk_valid,
  input logic       up_valid,
  input logic       pred_valid,
  input logic [1:0] pred_ctr,
  input logic       pred_taken,
  input logic       mispredict
);

  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);                                         // R3

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);                                       // R10

  AST_IDLE_ZERO_CTR: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> (pred_ctr == 2'b00) && !pred_taken);              // R10

  AST_MISP_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> !mispredict);                                       // R6

  AST_TAKEN_NEEDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_valid);                                       // R3

endmodule

bind twobit_branch_predictor twobit_bp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .up_valid   (up_valid),
  .pred_valid (pred_valid),
  .pred_ctr   (pred_ctr),
  .pred_taken (pred_taken),
  .mispredict (mispredict)
);

// File: tb/twobit_branch_predictor_bench.sv
`timescale 1ns/1ps
module twobit_branch_predictor_bench;

  localparam int PC_W = 32;
  localparam int NSLOT = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            lk_valid = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            pred_valid;
  logic [1:0]      pred_ctr;
  logic            pred_taken;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;
  logic            mispredict;

  int checks = 0;
  int failures = 0;
  logic [1:0] model [NSLOT];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  twobit_branch_predictor u_twobit_branch_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_ctr(pred_ctr), .pred_taken(pred_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .mispredict(mispredict)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got={valid,ctr,taken,misp}=%b expected=%b", req, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, read the model before updating it,
  // and sample the registered outputs 1 ns after the rising edge.
  task automatic step(input string req, input logic lv, input logic [31:0] lpc,
                      input logic uv, input logic [31:0] upc, input logic ut);
    logic [1:0] ectr;
    logic emp;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    ectr = lv ? model[lpc[7:2]] : 2'b00;
    emp  = uv && (ut != model[upc[7:2]][1]);
    if (uv) begin
      if (ut) model[upc[7:2]] = (model[upc[7:2]] == 2'b11) ? 2'b11 : model[upc[7:2]] + 2'd1;
      else    model[upc[7:2]] = (model[upc[7:2]] == 2'b00) ? 2'b00 : model[upc[7:2]] - 2'd1;
    end
    @(posedge clk);
    #1;
    check(req, {pred_valid, pred_ctr, pred_taken, mispredict}, {lv, ectr, ectr[1], emp});
  endtask

  function automatic logic [31:0] pc_of(input int slot, input logic [31:0] noise);
    return {noise[31:8], slot[5:0], noise[1:0]};
  endfunction

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) model[i] = 2'b01;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared during reset
    check("R1", {pred_valid, pred_ctr, pred_taken, mispredict}, 5'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1 and R2: every slot reads 01 with random low and high address bits
    for (int s = 0; s < NSLOT; s++) begin
      rng = next_rng(rng);
      step("R1", 1'b1, pc_of(s, rng), 1'b0, '0, 1'b0);
    end

    // R4: taken updates saturate at 11
    for (int k = 0; k < 4; k++) step("R4", 1'b0, '0, 1'b1, pc_of(5, 32'h0), 1'b1);
    step("R4", 1'b1, pc_of(5, 32'hFFFF_FF03), 1'b0, '0, 1'b0);
    // R7: from strong taken, one miss keeps the taken guess, the second flips it
    step("R7", 1'b0, '0, 1'b1, pc_of(5, 32'h0), 1'b0);
    step("R7", 1'b1, pc_of(5, 32'h0), 1'b0, '0, 1'b0);
    step("R7", 1'b0, '0, 1'b1, pc_of(5, 32'h0), 1'b0);
    step("R7", 1'b1, pc_of(5, 32'h0), 1'b0, '0, 1'b0);
    // R5: not-taken updates saturate at 00, R6 flags only on disagreement
    for (int k = 0; k < 3; k++) step("R5", 1'b1, pc_of(5, 32'h0), 1'b1, pc_of(5, 32'h0), 1'b0);
    step("R5", 1'b1, pc_of(5, 32'h0), 1'b0, '0, 1'b0);
    // R7 mirror: from strong not-taken, two taken outcomes needed
    step("R7", 1'b0, '0, 1'b1, pc_of(5, 32'h0), 1'b1);
    step("R7", 1'b1, pc_of(5, 32'h0), 1'b1, pc_of(5, 32'h0), 1'b1);
    step("R6", 1'b1, pc_of(5, 32'h0), 1'b1, pc_of(5, 32'h0), 1'b1);

    // R8: lookup and update on the same slot in one cycle return the old value
    step("R8", 1'b1, pc_of(9, 32'h0), 1'b1, pc_of(9, 32'h0), 1'b1);
    step("R8", 1'b1, pc_of(9, 32'h0), 1'b1, pc_of(9, 32'h0), 1'b1);
    step("R8", 1'b1, pc_of(9, 32'h0), 1'b0, '0, 1'b0);

    // R2: aliasing through bits above 7 and bits [1:0]
    step("R2", 1'b0, '0, 1'b1, pc_of(20, 32'hA500_0001), 1'b1);
    step("R2", 1'b1, pc_of(20, 32'h5A00_0002), 1'b0, '0, 1'b0);

    // R10: idle cycle gives no result
    step("R10", 1'b0, pc_of(9, 32'h0), 1'b0, '0, 1'b0);

    // R9, R6, R3: mixed traffic over a small pool of slots so collisions are frequent
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r1, r2;
      rng = next_rng(rng); r1 = rng;
      rng = next_rng(rng); r2 = rng;
      step("R9", r1[0] | r1[1], pc_of(int'(r1[10:8]) + (r1[11] ? 56 : 0), r2),
           r1[2] | r1[3], pc_of(int'(r1[14:12]) + (r1[15] ? 56 : 0), {r2[15:0], r2[31:16]}),
           r1[16]);
    end

    // R9: full sweep confirms untouched slots still hold their values
    for (int s = 0; s < NSLOT; s++) step("R9", 1'b1, pc_of(s, 32'h0), 1'b0, '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule